// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block supervises software by counting enabled clock ticks in a hidden 16-bit counter. If software does not clear the counter before a chosen interval runs out, the block asks the system for a soft reset. The same counter can instead work as a periodic interval timer. In that mode each elapsed interval raises an interrupt pulse and the count simply starts again.

Software reaches the block through a single 16-bit control word. Every write must carry a fixed key of 0x5A in its upper byte. A write with any other upper byte is treated as a runaway program and requests a reset at once. Reads return a different constant, 0x69, in the upper byte, so blindly writing back a value that was read also trips the reset. The counter advances on one of two clock-enable inputs, and a sticky flag records that a supervision timeout has happened. That flag survives the soft reset the block itself triggers and is cleared only by power-on reset.

Top module: `keyed_watchdog`

## Requirements
- R1: A write whose upper byte is not 0x5A leaves the control state unchanged and drives `rst_req` high in the cycle after the write.
- R2: Reads return 0x69 in bits 15:8 and the control byte in bits 7:0 as hold (7), two reserved storage bits (6:5), mode (4), clear reading 0 (3), source (2), interval select (1:0). Writing back a value that was read therefore requests a reset.
- R3: Interval select 00, 01, 10, 11 makes an interval of 32768, 8192, 512 and 64 enabled ticks. 00 is the value after power-on reset.
- R4: A keyed write with bit 3 set restarts the count from zero, so the next interval is a full interval.
- R5: While hold (bit 7) is 1, the counter does not advance and no interval elapses.
- R6: With mode 0 (supervisor, the power-on default), an elapsed interval gives a one-cycle `rst_req` pulse and sets `tmo_flag`. The timer runs from power-on reset.
- R7: With mode 1 (interval timer), every elapsed interval gives a one-cycle `irq` pulse with no `rst_req`, and intervals repeat back to back.
- R8: `tmo_flag` is cleared only by `por`. `sys_rst` zeroes the counter but keeps the control byte and the flag.
- R9: Source bit 2 at 0 counts cycles with `fast_ce` high; at 1 it counts cycles with `slow_ce` high. Other cycles do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System soft reset, clears only the counter |
| fast_ce | input | 1 | Tick enable of the fast clock source |
| slow_ce | input | 1 | Tick enable of the slow clock source |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data, key in bits 15:8 |
| reg_rdata | output | 16 | Control word read data |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Interval interrupt pulse |
| tmo_flag | output | 1 | Sticky supervision timeout flag |

## Verification
The bench counts the exact number of enabled ticks until each expiry for all four interval selects. An off-by-one compare or a wrong tap would move that count. It checks that a clear in the middle of an interval restarts a full interval rather than finishing the old one, and that a held or unselected source never advances the count. It also confirms that a read value written back trips a reset and that the timeout flag survives a soft reset but not power-on. A randomized phase mixes keyed and unkeyed writes, both enables, hold and soft resets against a tick-level model, which exposes priority slips between clear, tick and reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int NUM_SEL  = 4;
    localparam int BIT_HOLD = 7;
    localparam int BIT_RSVH = 6;
    localparam int BIT_RSVL = 5;
    localparam int BIT_MODE = 4;
    localparam int BIT_CLR  = 3;
    localparam int BIT_SRC  = 2;

    typedef enum logic [1:0] {
        IVL_LONG  = 2'b00,
        IVL_MID   = 2'b01,
        IVL_SHORT = 2'b10,
        IVL_TINY  = 2'b11
    } ivl_e;

    typedef struct packed {
        logic       hold;
        logic [1:0] rsv;
        logic       ivl_mode;
        logic       src_slow;
        ivl_e       ivl;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{hold: 1'b0, rsv: 2'b00, ivl_mode: 1'b0,
                                   src_slow: 1'b0, ivl: IVL_LONG};

    // counter bit whose reach ends the interval
    function automatic int tap_of(input logic [1:0] sel);
        case (sel)
            2'b00:   tap_of = 15;
            2'b01:   tap_of = 13;
            2'b10:   tap_of = 9;
            default: tap_of = 6;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.hold     = b[BIT_HOLD];
        c.rsv      = b[BIT_RSVH:BIT_RSVL];
        c.ivl_mode = b[BIT_MODE];
        c.src_slow = b[BIT_SRC];
        c.ivl      = ivl_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        logic [7:0] b;
        b            = '0;
        b[BIT_HOLD]  = c.hold;
        b[BIT_RSVH:BIT_RSVL] = c.rsv;
        b[BIT_MODE]  = c.ivl_mode;
        b[BIT_CLR]   = 1'b0;
        b[BIT_SRC]   = c.src_slow;
        b[1:0]       = c.ivl;
        return b;
    endfunction

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
    import wdt_pkg::*;
#(
    parameter logic [7:0] WR_KEY = 8'h5A,
    parameter logic [7:0] RD_KEY = 8'h69
) (
    input  logic        clk,
    input  logic        por,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output ctrl_t       ctrl_q,
    output logic        clr_req,
    output logic        bad_req,
    output logic [15:0] rd_data
);

    logic key_ok;

    assign key_ok  = (wr_data[15:8] == WR_KEY);
    assign clr_req = wr_en & key_ok & wr_data[BIT_CLR];
    assign bad_req = wr_en & ~key_ok;

    always_ff @(posedge clk) begin
        if (por) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en && key_ok) begin
            ctrl_q <= ctrl_from_byte(wr_data[7:0]);
        end
    end

    assign rd_data = {RD_KEY, ctrl_to_byte(ctrl_q)};

    // R1: an unkeyed write must not alter the control byte
    a_r1_ctrl_kept: assert property (@(posedge clk) disable iff (por)
        (wr_en && !key_ok) |=> $stable(ctrl_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic  clk,
    input  logic  por,
    input  logic  sys_rst,
    input  logic  clr_req,
    input  logic  fast_ce,
    input  logic  slow_ce,
    input  ctrl_t ctrl_q,
    output logic  expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val [NUM_SEL];
    logic             ce_sel;
    logic             tick;
    logic             at_last;

    for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_lim
        localparam int TAP = tap_of(2'(gi));
        assign last_val[gi] = CNT_W'((1 << TAP) - 1);
    end

    assign ce_sel  = ctrl_q.src_slow ? slow_ce : fast_ce;
    assign tick    = ~ctrl_q.hold & ce_sel;
    assign at_last = (cnt_q >= last_val[ctrl_q.ivl]);
    assign expire  = tick & at_last & ~sys_rst & ~clr_req;

    always_ff @(posedge clk) begin
        if (por || sys_rst) begin
            cnt_q <= '0;
        end else if (clr_req) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R4: a clear leaves the count at zero
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (por)
        (clr_req && !sys_rst) |=> (cnt_q == '0));

    // R5: a held counter keeps its value
    a_r5_hold_freeze: assert property (@(posedge clk) disable iff (por)
        (ctrl_q.hold && !clr_req && !sys_rst) |=> $stable(cnt_q));

    // R9: no advance on a cycle whose selected enable is low
    a_r9_no_tick: assert property (@(posedge clk) disable iff (por)
        (!(ctrl_q.src_slow ? slow_ce : fast_ce) && !clr_req && !sys_rst) |=> $stable(cnt_q));

    // R3: the count never passes the longest interval
    a_r3_bound: assert property (@(posedge clk) disable iff (por)
        cnt_q <= last_val[0]);

endmodule

// File: rtl/wdt_event.sv
module wdt_event (
    input  logic clk,
    input  logic por,
    input  logic expire,
    input  logic ivl_mode,
    input  logic bad_req,
    output logic rst_req,
    output logic irq,
    output logic tmo_flag
);

    always_ff @(posedge clk) begin
        if (por) begin
            rst_req  <= 1'b0;
            irq      <= 1'b0;
            tmo_flag <= 1'b0;
        end else begin
            rst_req <= bad_req | (expire & ~ivl_mode);
            irq     <= expire & ivl_mode;
            if (expire && !ivl_mode) begin
                tmo_flag <= 1'b1;
            end
        end
    end

    // R8: the flag never falls without power-on reset
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (por)
        tmo_flag |=> tmo_flag);

    // R6: the flag rises together with a reset request
    a_r6_flag_with_rst: assert property (@(posedge clk) disable iff (por)
        $rose(tmo_flag) |-> rst_req);

    // R7: an interval interrupt arrives without a reset unless a bad write coincided
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (por)
        (expire && ivl_mode && !bad_req) |=> (irq && !rst_req));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int         CNT_W  = 16,
    parameter logic [7:0] WR_KEY = 8'h5A,
    parameter logic [7:0] RD_KEY = 8'h69
) (
    input  logic        clk,
    input  logic        por,
    input  logic        sys_rst,
    input  logic        fast_ce,
    input  logic        slow_ce,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        rst_req,
    output logic        irq,
    output logic        tmo_flag
);

    ctrl_t ctrl_q;
    logic  clr_req;
    logic  bad_req;
    logic  expire;

    wdt_regif #(.WR_KEY(WR_KEY), .RD_KEY(RD_KEY)) u_regif (
        .clk     (clk),
        .por     (por),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .ctrl_q  (ctrl_q),
        .clr_req (clr_req),
        .bad_req (bad_req),
        .rd_data (reg_rdata)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .por     (por),
        .sys_rst (sys_rst),
        .clr_req (clr_req),
        .fast_ce (fast_ce),
        .slow_ce (slow_ce),
        .ctrl_q  (ctrl_q),
        .expire  (expire)
    );

    wdt_event u_event (
        .clk      (clk),
        .por      (por),
        .expire   (expire),
        .ivl_mode (ctrl_q.ivl_mode),
        .bad_req  (bad_req),
        .rst_req  (rst_req),
        .irq      (irq),
        .tmo_flag (tmo_flag)
    );

    // R1: an unkeyed write requests a reset on the next cycle
    a_r1_bad_key_rst: assert property (@(posedge clk) disable iff (por)
        (reg_wr && reg_wdata[15:8] != WR_KEY) |=> rst_req);

    // R2: the read key is always present
    a_r2_read_key: assert property (@(posedge clk) disable iff (por)
        reg_rdata[15:8] == RD_KEY);

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        sys_rst = 1'b0;
    logic        fast_ce = 1'b0;
    logic        slow_ce = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rst_req;
    logic        irq;
    logic        tmo_flag;

    int n_chk = 0;
    int n_err = 0;

    // bench model of the control byte and count
    logic       m_hold, m_mode, m_src;
    logic [1:0] m_rsv, m_sel;
    int         m_cnt;

    always #(PERIOD/2) clk = ~clk;

    keyed_watchdog u0 (
        .clk       (clk),
        .por       (por),
        .sys_rst   (sys_rst),
        .fast_ce   (fast_ce),
        .slow_ce   (slow_ce),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rst_req   (rst_req),
        .irq       (irq),
        .tmo_flag  (tmo_flag)
    );

    function automatic int ivl_len(input logic [1:0] s);
        case (s)
            2'b00:   return 32768;
            2'b01:   return 8192;
            2'b10:   return 512;
            default: return 64;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd();
        return {8'h69, m_hold, m_rsv, m_mode, 1'b0, m_src, m_sel};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr16(input logic [15:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic do_por();
        @(negedge clk);
        por = 1'b1;
        @(negedge clk);
        por = 1'b0;
    endtask

    task automatic measure(input int lim, output int k, output bit g_irq, output bit g_rst);
        k = 0; g_irq = 1'b0; g_rst = 1'b0;
        while (k < lim && !g_irq && !g_rst) begin
            @(negedge clk);
            k++;
            g_irq = irq;
            g_rst = rst_req;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        int  k;
        bit  gi, gr;
        logic [15:0] rv;
        bit  e_irq, e_rst, e_flag;
        void'($urandom(32'd1234));

        // reset state
        do_por();
        chk(reg_rdata == 16'h6900, "R2/R3 reset read", reg_rdata, 16'h6900);
        chk(!rst_req && !irq && !tmo_flag, "R6 outputs idle after reset", {rst_req, irq, tmo_flag}, 0);

        // R1 bad key
        wr16(16'h1234);
        chk(rst_req == 1'b1, "R1 bad key requests reset", rst_req, 1);
        @(negedge clk);
        chk(rst_req == 1'b0, "R1 reset request is one pulse", rst_req, 0);
        chk(reg_rdata == 16'h6900, "R1 control unchanged", reg_rdata, 16'h6900);

        // R2 write-back of read value
        rv = reg_rdata;
        wr16(rv);
        chk(rst_req == 1'b1, "R2 written-back read value resets", rst_req, 1);

        // R2/R4 keyed write, clear bit reads 0, reserved kept
        wr16(16'h5A6F);
        chk(reg_rdata == 16'h6967, "R4 clear reads zero, R2 layout", reg_rdata, 16'h6967);
        chk(rst_req == 1'b0, "R1 keyed write no reset", rst_req, 0);

        // R3/R7 interval 64 with fast source
        fast_ce = 1'b1;
        wr16(16'h5A1B);
        measure(40000, k, gi, gr);
        chk(gi && !gr && k == 64, "R3/R7 first 64 interval", k, 64);
        @(negedge clk);
        chk(irq == 1'b0, "R7 irq one pulse", irq, 0);
        measure(40000, k, gi, gr);
        chk(gi && !gr && k == 63, "R7 repeated interval", k, 63);

        // R4 clear midway restarts full interval
        repeat (40) @(negedge clk);
        wr16(16'h5A1B);
        measure(40000, k, gi, gr);
        chk(gi && k == 64, "R4 clear restarts interval", k, 64);

        // R3 other selects
        wr16(16'h5A1A);
        measure(40000, k, gi, gr);
        chk(gi && k == 512, "R3 select 10 gives 512", k, 512);
        wr16(16'h5A19);
        measure(40000, k, gi, gr);
        chk(gi && k == 8192, "R3 select 01 gives 8192", k, 8192);

        // R5 hold
        wr16(16'h5A9B);
        measure(300, k, gi, gr);
        chk(!gi && !gr, "R5 held counter never expires", gi, 0);
        wr16(16'h5A13);
        measure(40000, k, gi, gr);
        chk(gi && k == 64, "R5 count resumes from held value", k, 64);

        // R9 slow source
        slow_ce = 1'b0;
        wr16(16'h5A1F);
        measure(200, k, gi, gr);
        chk(!gi, "R9 fast ticks ignored on slow source", gi, 0);
        slow_ce = 1'b1;
        measure(40000, k, gi, gr);
        chk(gi && k == 64, "R9 slow ticks counted", k, 64);
        slow_ce = 1'b0;

        // R6 default supervisor from power-on
        do_por();
        measure(40000, k, gi, gr);
        chk(gr && !gi && k == 32768, "R6/R3 default timeout 32768", k, 32768);
        chk(tmo_flag == 1'b1, "R6 flag set on timeout", tmo_flag, 1);
        @(negedge clk);
        chk(rst_req == 1'b0, "R6 timeout reset is one pulse", rst_req, 0);

        // R8 soft reset keeps flag and control, clears count
        wr16(16'h5A12);
        @(negedge clk);
        sys_rst = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0;
        chk(tmo_flag == 1'b1, "R8 flag survives soft reset", tmo_flag, 1);
        chk(reg_rdata == 16'h6912, "R8 control survives soft reset", reg_rdata, 16'h6912);
        measure(40000, k, gi, gr);
        chk(gi && k == 512, "R8 soft reset clears count", k, 512);
        do_por();
        chk(tmo_flag == 1'b0, "R8 power-on clears flag", tmo_flag, 0);

        // randomized phase against the tick model
        do_por();
        m_hold = 0; m_mode = 0; m_src = 0; m_rsv = 0; m_sel = 0; m_cnt = 0;
        e_irq = 0; e_rst = 0; e_flag = 0;
        for (int i = 0; i < 4000; i++) begin
            bit do_wr, good, srst, tick;
            logic [7:0] hi, lo;
            chk(irq == e_irq, "R7 random irq", irq, e_irq);
            chk(rst_req == e_rst, "R1/R6 random reset request", rst_req, e_rst);
            chk(tmo_flag == e_flag, "R8 random flag", tmo_flag, e_flag);
            chk(reg_rdata == exp_rd(), "R2 random read", reg_rdata, exp_rd());

            fast_ce = 1'($urandom_range(0, 1));
            slow_ce = 1'($urandom_range(0, 1));
            srst    = ($urandom_range(0, 199) == 0);
            do_wr   = !srst && ($urandom_range(0, 39) == 0);
            good    = ($urandom_range(0, 7) != 0);
            hi      = good ? 8'h5A : 8'($urandom_range(0, 255));
            if (hi == 8'h5A && !good) hi = 8'h00;
            lo      = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) != 0) lo[1:0] = 2'b11;
            if ($urandom_range(0, 3) != 0) lo[7] = 1'b0;
            sys_rst   = srst;
            reg_wr    = do_wr;
            reg_wdata = {hi, lo};

            tick  = !m_hold && (m_src ? slow_ce : fast_ce);
            e_irq = 0;
            e_rst = 0;
            if (srst) begin
                m_cnt = 0;
            end else if (do_wr && good && lo[3]) begin
                m_cnt = 0;
            end else if (tick) begin
                if (m_cnt >= ivl_len(m_sel) - 1) begin
                    m_cnt = 0;
                    if (m_mode) e_irq = 1;
                    else begin e_rst = 1; e_flag = 1; end
                end else begin
                    m_cnt++;
                end
            end
            if (do_wr && !good) e_rst = 1;
            if (do_wr && good) begin
                m_hold = lo[7]; m_rsv = lo[6:5]; m_mode = lo[4];
                m_src = lo[2]; m_sel = lo[1:0];
            end
            @(negedge clk);
        end
        sys_rst = 1'b0;
        reg_wr  = 1'b0;
        finish_run();
    end

endmodule